// File: doc/BRIEF.md
# Power-up reset delay sequencer

This block keeps a processor core in reset after a power event until the supply and the clock can both be trusted. It reacts to three reset sources: a power-on pulse (which also acts as the block's own asynchronous reset), a brown-out pulse and an active-low external reset pin. After a source goes away, the block runs a chain of timeouts and then releases the core.

The chain has up to three stages. An optional power-up delay is counted in ticks of an internal slow time base. It runs only after a power-on or brown-out event. An oscillator settle count follows, which counts oscillator edge strobes and is used only for crystal modes. In the crystal-with-PLL mode, a lock wait comes last. The lock wait reuses the power-up delay counter. The core release rises through a two-stage synchronizer on the core clock. Outputs report the current stage and which source caused the most recent reset.

A new reset event arriving mid-sequence aborts it and restarts from the stage that suits that event. A pin event never re-runs the power-up delay.

Top module: `prs_powerup_seq`

## Requirements
- R1: While and right after `por_i` is high, `stage_o` is 1 (power-up delay), `cause_o` is 3'b001 and `core_release_o` is 0.
- R2: With `pwrup_en_i` high, the power-up delay stage lasts exactly PWRUP_TICKS*DIV clock cycles from its entry.
- R3: With `pwrup_en_i` low (sampled during the stage), the power-up delay stage lasts exactly one cycle.
- R4: In crystal modes (`osc_mode_i` 2'b00 or 2'b11) the settle stage (code 2) ends on the cycle that carries the OST_EDGES-th `osc_edge_i` strobe seen in that stage.
- R5: In external-clock (2'b01) and RC (2'b10) modes the settle stage is skipped and the block goes straight to run (code 4).
- R6: In mode 2'b11 a lock stage (code 3) follows the settle stage and lasts exactly LOCK_TICKS*DIV cycles before run.
- R7: A `bor_i` pulse in any stage makes the next cycle show stage 1, cause 3'b010 and release 0, and restarts the delay count.
- R8: While `mclr_n_i` is low the block holds in stage 0 with cause 3'b100 and release 0. Once the pin goes high it continues with the settle stage (crystal) or run, and never with the power-up delay.
- R9: `core_release_o` rises exactly two cycles after the stage enters run. It falls on the same edge at which any reset event takes effect.
- R10: Stage codes are 0 pin hold, 1 power-up delay, 2 oscillator settle, 3 PLL lock, 4 run. `cause_o` is always one-hot: bit0 power-on, bit1 brown-out, bit2 pin.
- R11: Oscillator strobes seen before the settle stage starts do not count toward its total.
- R12: When `bor_i` and a low `mclr_n_i` arrive in the same cycle, the brown-out wins: stage 1, cause 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running core clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| bor_i | input | 1 | Brown-out reset pulse, synchronous |
| mclr_n_i | input | 1 | External reset pin, active low |
| pwrup_en_i | input | 1 | Enables the power-up delay |
| osc_mode_i | input | 2 | Oscillator mode: 00 crystal, 01 external clock, 10 RC, 11 crystal with PLL |
| osc_edge_i | input | 1 | One-cycle strobe per oscillator edge |
| core_release_o | output | 1 | High when the core may leave reset |
| stage_o | output | 3 | Current stage code |
| cause_o | output | 3 | One-hot cause of the last reset |

## Verification
The bench measures each stage length exactly in cycles. A divider that does not restart at stage entry, or a counter off by one, shows up as a delay of 31 or 33 instead of 32. It feeds oscillator strobes throughout the power-up delay. A settle counter that is not cleared at entry would then finish early. It checks that a pin event resumes at the settle stage and not at the power-up delay, that brown-out wins over a simultaneous pin event, and that release lags run entry by exactly two cycles but drops at once. Random runs with mid-sequence aborts are compared cycle by cycle against a bench model.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [2:0] {
        ST_HOLD  = 3'd0,
        ST_PWRUP = 3'd1,
        ST_OST   = 3'd2,
        ST_LOCK  = 3'd3,
        ST_RUN   = 3'd4
    } stage_e;

    typedef enum logic [1:0] {
        OSC_XTAL     = 2'b00,
        OSC_EXT      = 2'b01,
        OSC_RC       = 2'b10,
        OSC_XTAL_PLL = 2'b11
    } osc_mode_e;

    localparam logic [2:0] CAUSE_POR = 3'b001;
    localparam logic [2:0] CAUSE_BOR = 3'b010;
    localparam logic [2:0] CAUSE_PIN = 3'b100;

    // Stage that follows the power-up delay (or a pin hold) for a mode.
    function automatic stage_e after_pwrup(input logic [1:0] mode);
        if (mode == OSC_XTAL || mode == OSC_XTAL_PLL) begin
            return ST_OST;
        end
        return ST_RUN;
    endfunction

endpackage

// File: rtl/prs_slow_timer.sv
// Slow time base and tick counter shared by the power-up and lock stages.
module prs_slow_timer #(
    parameter int DIV   = 16,
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             done_o
);
    localparam int             DIV_W    = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] cnt;
    } slow_t;

    slow_t q, d;
    logic  tick;

    always_comb begin
        d    = q;
        tick = run_i && (q.div == DIV_LAST);
        if (clr_i) begin
            d = '0;
        end else if (run_i) begin
            d.div = tick ? '0 : q.div + 1'b1;
            if (tick) begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    assign done_o = tick && (q.cnt == target_i - 1'b1);

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R2 / R6: the count never passes the stage target.
    assert_slow_bound_R2: assert property (@(posedge clk_i) disable iff (arst_i)
        run_i |-> (q.cnt < target_i));
    assert_div_bound_R6: assert property (@(posedge clk_i) disable iff (arst_i)
        q.div <= DIV_LAST);

endmodule

// File: rtl/prs_ost_counter.sv
// Counts oscillator edge strobes during the settle stage.
module prs_ost_counter #(
    parameter int EDGES = 1024
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic clr_i,
    input  logic run_i,
    input  logic edge_i,
    output logic done_o
);
    localparam int           W    = $clog2(EDGES + 1);
    localparam logic [W-1:0] LAST = W'(EDGES - 1);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (run_i && edge_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && edge_i && (cnt_q == LAST);

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4: the settle count ends at its last value and never goes past it.
    assert_ost_bound_R4: assert property (@(posedge clk_i) disable iff (arst_i)
        cnt_q <= LAST);
    assert_ost_frozen_R11: assert property (@(posedge clk_i) disable iff (arst_i)
        (!run_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/prs_release_sync.sv
// Two-flop release path: rises two cycles after run entry, drops at once.
module prs_release_sync (
    input  logic clk_i,
    input  logic arst_i,
    input  logic run_now_i,
    input  logic run_next_i,
    output logic release_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.s1 = run_now_i && run_next_i;
        d.s2 = q.s1 && run_next_i;
    end

    assign release_o = q.s2;

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assert_release_in_run_R9: assert property (@(posedge clk_i) disable iff (arst_i)
        release_o |-> run_now_i);
    assert_release_lag_R9: assert property (@(posedge clk_i) disable iff (arst_i)
        $rose(release_o) |-> ($past(run_now_i) && $past(run_now_i, 2)));

endmodule

// File: rtl/prs_powerup_seq.sv
module prs_powerup_seq
    import prs_pkg::*;
#(
    parameter int DIV         = 64,
    parameter int PWRUP_TICKS = 1024,
    parameter int LOCK_TICKS  = 32,
    parameter int OST_EDGES   = 1024
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       bor_i,
    input  logic       mclr_n_i,
    input  logic       pwrup_en_i,
    input  logic [1:0] osc_mode_i,
    input  logic       osc_edge_i,
    output logic       core_release_o,
    output logic [2:0] stage_o,
    output logic [2:0] cause_o
);
    localparam int MAX_TICKS = (PWRUP_TICKS > LOCK_TICKS) ? PWRUP_TICKS : LOCK_TICKS;
    localparam int SLOW_W    = $clog2(MAX_TICKS + 1);
    localparam logic [SLOW_W-1:0] PWRUP_T = SLOW_W'(PWRUP_TICKS);
    localparam logic [SLOW_W-1:0] LOCK_T  = SLOW_W'(LOCK_TICKS);

    typedef struct packed {
        stage_e     stage;
        logic [2:0] cause;
    } seq_t;

    seq_t              q, d;
    logic              restart;
    logic              clr;
    logic              slow_run;
    logic              slow_done;
    logic              ost_done;
    logic [SLOW_W-1:0] slow_target;

    always_comb begin
        d       = q;
        restart = 1'b0;
        if (bor_i) begin
            d.stage = ST_PWRUP;
            d.cause = CAUSE_BOR;
            restart = 1'b1;
        end else if (!mclr_n_i) begin
            d.stage = ST_HOLD;
            d.cause = CAUSE_PIN;
            restart = 1'b1;
        end else begin
            case (q.stage)
                ST_HOLD:  d.stage = after_pwrup(osc_mode_i);
                ST_PWRUP: if (!pwrup_en_i || slow_done) d.stage = after_pwrup(osc_mode_i);
                ST_OST:   if (ost_done) d.stage = (osc_mode_i == OSC_XTAL_PLL) ? ST_LOCK : ST_RUN;
                ST_LOCK:  if (slow_done) d.stage = ST_RUN;
                ST_RUN:   d.stage = ST_RUN;
                default:  d.stage = ST_PWRUP;
            endcase
        end
    end

    assign clr         = restart || (d.stage != q.stage);
    assign slow_run    = (q.stage == ST_PWRUP) || (q.stage == ST_LOCK);
    assign slow_target = (q.stage == ST_LOCK) ? LOCK_T : PWRUP_T;

    prs_slow_timer #(
        .DIV   (DIV),
        .CNT_W (SLOW_W)
    ) u_slow (
        .clk_i    (clk_i),
        .arst_i   (por_i),
        .clr_i    (clr),
        .run_i    (slow_run),
        .target_i (slow_target),
        .done_o   (slow_done)
    );

    prs_ost_counter #(
        .EDGES (OST_EDGES)
    ) u_ost (
        .clk_i  (clk_i),
        .arst_i (por_i),
        .clr_i  (clr),
        .run_i  (q.stage == ST_OST),
        .edge_i (osc_edge_i),
        .done_o (ost_done)
    );

    prs_release_sync u_rel (
        .clk_i      (clk_i),
        .arst_i     (por_i),
        .run_now_i  (q.stage == ST_RUN),
        .run_next_i (d.stage == ST_RUN),
        .release_o  (core_release_o)
    );

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            q.stage <= ST_PWRUP;
            q.cause <= CAUSE_POR;
        end else begin
            q <= d;
        end
    end

    assign stage_o = q.stage;
    assign cause_o = q.cause;

    assert_cause_onehot_R10: assert property (@(posedge clk_i) disable iff (por_i)
        $onehot(cause_o));
    assert_bor_restart_R7: assert property (@(posedge clk_i) disable iff (por_i)
        bor_i |=> (stage_o == 3'd1 && cause_o == CAUSE_BOR && !core_release_o));
    assert_pin_hold_R8: assert property (@(posedge clk_i) disable iff (por_i)
        (!mclr_n_i && !bor_i) |=> (stage_o == 3'd0 && !core_release_o));
    assert_lock_after_ost_R6: assert property (@(posedge clk_i) disable iff (por_i)
        (q.stage == ST_LOCK && $past(q.stage) != ST_LOCK) |-> ($past(q.stage) == ST_OST));
    assert_hold_skips_pwrup_R8: assert property (@(posedge clk_i) disable iff (por_i)
        (q.stage == ST_HOLD && mclr_n_i && !bor_i) |=> (q.stage != ST_PWRUP));

endmodule

// File: tb/sim_prs_powerup_seq.sv
`timescale 1ns/100ps
module sim_prs_powerup_seq;
    localparam int DIV = 4, PT = 8, LT = 5, OE = 16;

    logic clk = 1'b0;
    logic por = 1'b1, bor = 1'b0, mclr_n = 1'b1, pen = 1'b1, osc = 1'b0;
    logic [1:0] mode = 2'b00;
    logic rel;
    logic [2:0] stage, cause;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    prs_powerup_seq #(.DIV(DIV), .PWRUP_TICKS(PT), .LOCK_TICKS(LT), .OST_EDGES(OE)) u0 (
        .clk_i(clk), .por_i(por), .bor_i(bor), .mclr_n_i(mclr_n), .pwrup_en_i(pen),
        .osc_mode_i(mode), .osc_edge_i(osc), .core_release_o(rel), .stage_o(stage), .cause_o(cause));

    // Bench model built from the requirements.
    int m_stage = 1, m_cause = 1, m_div = 0, m_slow = 0, m_ost = 0;
    bit m_s1 = 0, m_s2 = 0;

    function automatic int exp_after(input logic [1:0] md);
        return (md == 2'b00 || md == 2'b11) ? 2 : 4;
    endfunction

    always @(posedge clk) begin
        if (por) begin
            m_stage = 1; m_cause = 1; m_div = 0; m_slow = 0; m_ost = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            int ns, tgt;
            bit sdone, odone, clr, tick, old_s1;
            tgt   = (m_stage == 3) ? LT : PT;
            tick  = (m_stage == 1 || m_stage == 3) && (m_div == DIV - 1);
            sdone = tick && (m_slow == tgt - 1);
            odone = (m_stage == 2) && osc && (m_ost == OE - 1);
            ns = m_stage;
            if (bor) begin ns = 1; m_cause = 2; end
            else if (!mclr_n) begin ns = 0; m_cause = 4; end
            else if (m_stage == 0) ns = exp_after(mode);
            else if (m_stage == 1) begin if (!pen || sdone) ns = exp_after(mode); end
            else if (m_stage == 2) begin if (odone) ns = (mode == 2'b11) ? 3 : 4; end
            else if (m_stage == 3) begin if (sdone) ns = 4; end
            clr = bor || !mclr_n || (ns != m_stage);
            if (clr) begin m_div = 0; m_slow = 0; m_ost = 0; end
            else begin
                if (m_stage == 1 || m_stage == 3) begin
                    m_div = tick ? 0 : m_div + 1;
                    if (tick) m_slow++;
                end
                if (m_stage == 2 && osc) m_ost++;
            end
            old_s1 = m_s1;
            m_s1 = (m_stage == 4) && (ns == 4);
            m_s2 = old_s1 && (ns == 4);
            m_stage = ns;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk("R10 stage vs model", int'(stage), m_stage);
        chk("R10 cause vs model", int'(cause), m_cause);
        chk("R9 release vs model", int'(rel), int'(m_s2));
        chk("R10 cause one-hot", $countones(cause), 1);
    endtask

    task automatic measure(input int st, output int n);
        n = 0;
        while (int'(stage) == st && n < 5000) begin
            n++;
            cyc();
        end
    endtask

    task automatic bor_pulse();
        bor = 1'b1; cyc(); bor = 1'b0;
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) cyc();
        chk("R1 stage", int'(stage), 1);
        chk("R1 cause", int'(cause), 1);
        chk("R1 release", int'(rel), 0);
        por = 1'b0; cyc();

        // Crystal mode, delay enabled, strobes present during the delay.
        osc = 1'b1; mode = 2'b00; pen = 1'b1;
        bor_pulse();
        chk("R7 cause after bor", int'(cause), 2);
        measure(1, n); chk("R2 power-up length", n, PT * DIV);
        chk("R4 settle follows delay", int'(stage), 2);
        measure(2, n); chk("R11 R4 settle length", n, OE);
        chk("R4 crystal goes to run", int'(stage), 4);
        n = 0;
        while (!rel && n < 100) begin n++; cyc(); end
        chk("R9 release lag", n, 2);

        bor_pulse();
        chk("R7 stage", int'(stage), 1);
        chk("R7 release drop", int'(rel), 0);

        // Delay disabled, external clock mode.
        pen = 1'b0; mode = 2'b01;
        bor_pulse();
        measure(1, n); chk("R3 disabled delay length", n, 1);
        chk("R5 external clock skips settle", int'(stage), 4);
        mode = 2'b10;
        bor_pulse(); cyc();
        chk("R5 RC skips settle", int'(stage), 4);

        // PLL mode.
        pen = 1'b1; mode = 2'b11;
        bor_pulse();
        measure(1, n); chk("R2 power-up length pll", n, PT * DIV);
        measure(2, n); chk("R4 settle length pll", n, OE);
        chk("R6 lock stage entered", int'(stage), 3);
        measure(3, n); chk("R6 lock length", n, LT * DIV);
        chk("R6 run after lock", int'(stage), 4);
        repeat (3) cyc();

        // Pin event.
        mode = 2'b00;
        mclr_n = 1'b0; repeat (3) cyc();
        chk("R8 hold stage", int'(stage), 0);
        chk("R8 hold cause", int'(cause), 4);
        chk("R8 hold release", int'(rel), 0);
        mclr_n = 1'b1; cyc();
        chk("R8 resumes at settle", int'(stage), 2);
        measure(2, n);
        chk("R8 run after pin", int'(stage), 4);

        // Brown-out and pin together.
        bor = 1'b1; mclr_n = 1'b0; cyc();
        chk("R12 stage", int'(stage), 1);
        chk("R12 cause", int'(cause), 2);
        bor = 1'b0; cyc();
        chk("R8 pin after bor", int'(stage), 0);
        mclr_n = 1'b1; cyc();

        // Random phase against the model.
        begin
            int pin_left = 0, por_left = 0;
            for (int i = 0; i < 8000; i++) begin
                osc = ($urandom % 2) == 0;
                bor = 1'b0;
                if (por_left > 0) por_left--;
                else if ($urandom % 2500 == 0) por_left = 2;
                por = (por_left > 0);
                if (pin_left > 0) pin_left--;
                else if ($urandom % 300 == 0) pin_left = 1 + ($urandom % 5);
                mclr_n = (pin_left == 0);
                if ($urandom % 250 == 0) begin
                    bor  = 1'b1;
                    mode = 2'($urandom % 4);
                    pen  = ($urandom % 4) != 0;
                end
                cyc();
            end
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule